// File: doc/BRIEF.md
# Indexed Colour Palette

This block is the colour palette behind the pseudo-colour display modes. It holds 256 colour entries, each a red, green and blue component kept at 4-bit precision. Every cycle the pixel side presents an 8-bit pixel index. One clock later the block returns the three components stored at that index. The pixel side never waits.

A byte-wide host port reaches the table through two registers, selected by one select line. The index register holds the entry that the host is working on. The data register is shared by all three components: a 2-bit phase steps through red, then green, then blue on successive data accesses. After the blue access the index moves to the next entry, so the host can load or read a run of entries after a single index write.

The lookup path has a narrow mode for 4 bits per pixel. In that mode only the low 16 entries can be reached.

Top module: `pal_lut`

## Requirements
- R1: After reset every entry holds zero in all three components, the index register holds 0, the phase is red, and pix_red, pix_grn, pix_blu and hst_rdata are all 0.
- R2: A host write with hst_sel=0 loads hst_wdata into the index register and returns the phase to red. A host read with hst_sel=0 returns the index register on hst_rdata one cycle later.
- R3: Host writes with hst_sel=1 store the upper nibble hst_wdata[7:4] into the red, green and blue component of the selected entry, in that order. Bits 3:0 are discarded.
- R4: A data access (read or write) in the blue phase increments the index by one, wrapping from 255 to 0. A data access in the red or green phase leaves the index unchanged.
- R5: A host read with hst_sel=1 returns the component named by the phase, one cycle later. The stored nibble appears in hst_rdata[7:4] and bits 3:0 are zero. The read advances the phase in the same way a write does.
- R6: With pix_narrow=0, pix_red, pix_grn and pix_blu show the entry addressed by pix_index one cycle after pix_index is sampled.
- R7: With pix_narrow=1, only pix_index[3:0] selects the entry, so the lookup reads entry (pix_index mod 16).
- R8: If a host write and a lookup hit the same entry in the same cycle, the lookup returns the old contents and the following lookup returns the new contents. The lookup is never stalled.
- R9: When hst_wr and hst_rd are both high, only the write takes effect. hst_rdata keeps its previous value and the phase advances once. With neither strobe high, hst_rdata also holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| hst_wr | input | 1 | Host write strobe |
| hst_rd | input | 1 | Host read strobe |
| hst_sel | input | 1 | 0 selects the index register, 1 selects the data register |
| hst_wdata | input | 8 | Host write data |
| hst_rdata | output | 8 | Host read data, valid the cycle after a read |
| pix_index | input | 8 | Pixel index to look up |
| pix_narrow | input | 1 | 1 restricts the lookup to entries 0 to 15 |
| pix_red | output | 4 | Red component of the looked-up entry |
| pix_grn | output | 4 | Green component of the looked-up entry |
| pix_blu | output | 4 | Blue component of the looked-up entry |

## Verification
The assertions check four properties on every cycle:
- the phase register never takes an unused code;
- an index write reloads the index and returns the phase to red;
- the index advances only after a blue-phase access and otherwise holds;
- read data keeps its low nibble at zero and holds whenever no plain read happens.

Only the bench scenarios can show that the correct entry and component receive each nibble, and that lookups in both modes return the entry's contents. Sweeps over all 256 entries through both the pixel side and host readback cover this. The bench also checks three timing cases: a lookup racing a write to the same entry, a simultaneous read and write strobe, and the index wrapping from 255 to 0.

// File: rtl/pal_lut_pkg.sv
package pal_lut_pkg;

    localparam int HOST_W = 8;
    localparam int COMP_W = 4;
    localparam int COMP_N = 3;

    typedef enum logic [1:0] {
        PH_RED = 2'd0,
        PH_GRN = 2'd1,
        PH_BLU = 2'd2
    } phase_e;

    typedef enum logic {
        SEL_INDEX = 1'b0,
        SEL_DATA  = 1'b1
    } hsel_e;

    typedef struct packed {
        logic [COMP_W-1:0] red;
        logic [COMP_W-1:0] grn;
        logic [COMP_W-1:0] blu;
    } rgb_t;

    function automatic phase_e phase_after(input phase_e p);
        case (p)
            PH_RED:  return PH_GRN;
            PH_GRN:  return PH_BLU;
            default: return PH_RED;
        endcase
    endfunction

    function automatic logic [COMP_W-1:0] pick_comp(input rgb_t e, input phase_e p);
        case (p)
            PH_RED:  return e.red;
            PH_GRN:  return e.grn;
            default: return e.blu;
        endcase
    endfunction

endpackage

// File: rtl/pal_lut_seq.sv
module pal_lut_seq
    import pal_lut_pkg::*;
#(
    parameter int IDX_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              addr_wr,
    input  logic              data_acc,
    input  logic [HOST_W-1:0] wdata,
    output logic [IDX_W-1:0]  cur_idx,
    output phase_e            cur_phase
);

    always_ff @(posedge clk) begin
        if (rst) begin
            cur_idx   <= '0;
            cur_phase <= PH_RED;
        end else if (addr_wr) begin
            cur_idx   <= wdata[IDX_W-1:0];
            cur_phase <= PH_RED;
        end else if (data_acc) begin
            if (cur_phase == PH_BLU) begin
                cur_idx   <= cur_idx + 1'b1;
                cur_phase <= PH_RED;
            end else begin
                cur_phase <= phase_after(cur_phase);
            end
        end
    end

    AST_PHASE_LEGAL: assert property (@(posedge clk) disable iff (rst)
        cur_phase != phase_e'(2'd3)); // R3

    AST_ADDR_LOAD: assert property (@(posedge clk) disable iff (rst)
        addr_wr |=> (cur_idx == $past(wdata[IDX_W-1:0])) && (cur_phase == PH_RED)); // R2

    AST_IDX_STEP: assert property (@(posedge clk) disable iff (rst)
        (!addr_wr && data_acc && cur_phase == PH_BLU) |=> cur_idx == $past(cur_idx) + 1'b1); // R4

    AST_IDX_HOLD: assert property (@(posedge clk) disable iff (rst)
        (!addr_wr && !(data_acc && cur_phase == PH_BLU)) |=> $stable(cur_idx)); // R4

endmodule

// File: rtl/pal_lut_store.sv
module pal_lut_store
    import pal_lut_pkg::*;
#(
    parameter int IDX_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  phase_e            wr_phase,
    input  logic [COMP_W-1:0] wr_nib,
    input  logic [IDX_W-1:0]  pix_idx,
    output rgb_t              pix_entry,
    input  logic [IDX_W-1:0]  host_idx,
    output rgb_t              host_entry
);

    localparam int ENTRIES = 1 << IDX_W;

    logic [COMP_W-1:0] comp_pix  [COMP_N];
    logic [COMP_W-1:0] comp_host [COMP_N];

    for (genvar c = 0; c < COMP_N; c++) begin : g_comp
        logic [COMP_W-1:0] mem [ENTRIES];

        always_ff @(posedge clk) begin
            if (rst) begin
                for (int e = 0; e < ENTRIES; e++) mem[e] <= '0;
            end else if (wr_en && (wr_phase == phase_e'(c))) begin
                mem[wr_idx] <= wr_nib;
            end
        end

        assign comp_pix[c]  = mem[pix_idx];
        assign comp_host[c] = mem[host_idx];
    end

    assign pix_entry  = '{red: comp_pix[0],  grn: comp_pix[1],  blu: comp_pix[2]};
    assign host_entry = '{red: comp_host[0], grn: comp_host[1], blu: comp_host[2]};

endmodule

// File: rtl/pal_lut_pixport.sv
module pal_lut_pixport
    import pal_lut_pkg::*;
#(
    parameter int IDX_W    = 8,
    parameter int NARROW_W = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [IDX_W-1:0] pix_index,
    input  logic             pix_narrow,
    output logic [IDX_W-1:0] look_idx,
    input  rgb_t             entry,
    output rgb_t             entry_q
);

    localparam logic [IDX_W-1:0] NARROW_MASK = IDX_W'((1 << NARROW_W) - 1);

    assign look_idx = pix_narrow ? (pix_index & NARROW_MASK) : pix_index;

    always_ff @(posedge clk) begin
        if (rst) entry_q <= '0;
        else     entry_q <= entry;
    end

endmodule

// File: rtl/pal_lut.sv
module pal_lut
    import pal_lut_pkg::*;
#(
    parameter int IDX_W    = 8,
    parameter int NARROW_W = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              hst_wr,
    input  logic              hst_rd,
    input  logic              hst_sel,
    input  logic [HOST_W-1:0] hst_wdata,
    output logic [HOST_W-1:0] hst_rdata,
    input  logic [IDX_W-1:0]  pix_index,
    input  logic              pix_narrow,
    output logic [COMP_W-1:0] pix_red,
    output logic [COMP_W-1:0] pix_grn,
    output logic [COMP_W-1:0] pix_blu
);

    hsel_e            sel;
    logic             rd_only;
    logic             addr_wr;
    logic             data_acc;
    logic             data_wr;
    logic [IDX_W-1:0] cur_idx;
    phase_e           cur_phase;
    logic [IDX_W-1:0] look_idx;
    rgb_t             pix_entry;
    rgb_t             host_entry;
    rgb_t             pix_q;

    assign sel      = hsel_e'(hst_sel);
    assign rd_only  = hst_rd && !hst_wr;
    assign addr_wr  = hst_wr && (sel == SEL_INDEX);
    assign data_wr  = hst_wr && (sel == SEL_DATA);
    assign data_acc = (hst_wr || hst_rd) && (sel == SEL_DATA);

    pal_lut_seq #(.IDX_W(IDX_W)) seq_i (
        .clk       (clk),
        .rst       (rst),
        .addr_wr   (addr_wr),
        .data_acc  (data_acc),
        .wdata     (hst_wdata),
        .cur_idx   (cur_idx),
        .cur_phase (cur_phase)
    );

    pal_lut_store #(.IDX_W(IDX_W)) store_i (
        .clk        (clk),
        .rst        (rst),
        .wr_en      (data_wr),
        .wr_idx     (cur_idx),
        .wr_phase   (cur_phase),
        .wr_nib     (hst_wdata[HOST_W-1 -: COMP_W]),
        .pix_idx    (look_idx),
        .pix_entry  (pix_entry),
        .host_idx   (cur_idx),
        .host_entry (host_entry)
    );

    pal_lut_pixport #(.IDX_W(IDX_W), .NARROW_W(NARROW_W)) pix_i (
        .clk        (clk),
        .rst        (rst),
        .pix_index  (pix_index),
        .pix_narrow (pix_narrow),
        .look_idx   (look_idx),
        .entry      (pix_entry),
        .entry_q    (pix_q)
    );

    assign pix_red = pix_q.red;
    assign pix_grn = pix_q.grn;
    assign pix_blu = pix_q.blu;

    always_ff @(posedge clk) begin
        if (rst) begin
            hst_rdata <= '0;
        end else if (rd_only) begin
            if (sel == SEL_INDEX)
                hst_rdata <= HOST_W'(cur_idx);
            else
                hst_rdata <= {pick_comp(host_entry, cur_phase), {(HOST_W-COMP_W){1'b0}}};
        end
    end

    AST_RDATA_LOW_ZERO: assert property (@(posedge clk) disable iff (rst)
        (rd_only && sel == SEL_DATA) |=> hst_rdata[HOST_W-COMP_W-1:0] == '0); // R5

    AST_RDATA_HOLD: assert property (@(posedge clk) disable iff (rst)
        !rd_only |=> $stable(hst_rdata)); // R9

endmodule

// File: tb/pal_lut_tb_top.sv
module pal_lut_tb_top;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       hst_wr = 1'b0;
    logic       hst_rd = 1'b0;
    logic       hst_sel = 1'b0;
    logic [7:0] hst_wdata = '0;
    logic [7:0] hst_rdata;
    logic [7:0] pix_index = '0;
    logic       pix_narrow = 1'b0;
    logic [3:0] pix_red, pix_grn, pix_blu;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    logic [3:0] exp_c [3][256];
    logic [7:0] m_idx;
    int         m_ph;

    always #10 clk = ~clk;

    pal_lut dut_i (
        .clk(clk), .rst(rst), .hst_wr(hst_wr), .hst_rd(hst_rd), .hst_sel(hst_sel),
        .hst_wdata(hst_wdata), .hst_rdata(hst_rdata), .pix_index(pix_index),
        .pix_narrow(pix_narrow), .pix_red(pix_red), .pix_grn(pix_grn), .pix_blu(pix_blu)
    );

    task automatic check(input string req, input int got, input int exp);
        n_checks++;
        if (got != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, got, exp);
        end
    endtask

    function automatic logic [7:0] pattern(input int e, input int c);
        return 8'((e * 37 + c * 91 + 13) & 255);
    endfunction

    task automatic model_step();
        if (m_ph == 2) begin
            m_ph  = 0;
            m_idx = m_idx + 8'd1;
        end else begin
            m_ph++;
        end
    endtask

    task automatic hw(input logic sel, input logic [7:0] d);
        hst_sel = sel; hst_wdata = d; hst_wr = 1'b1;
        @(negedge clk);
        hst_wr = 1'b0;
        if (sel == 1'b0) begin
            m_idx = d; m_ph = 0;
        end else begin
            exp_c[m_ph][m_idx] = d[7:4];
            model_step();
        end
    endtask

    task automatic hr(input logic sel, output logic [7:0] d);
        hst_sel = sel; hst_rd = 1'b1;
        @(negedge clk);
        hst_rd = 1'b0;
        d = hst_rdata;
    endtask

    task automatic look(input logic [7:0] idx, input logic nar, output logic [11:0] rgb);
        pix_index = idx; pix_narrow = nar;
        @(negedge clk);
        rgb = {pix_red, pix_grn, pix_blu};
    endtask

    function automatic int exp_rgb(input int e);
        return int'({exp_c[0][e], exp_c[1][e], exp_c[2][e]});
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        logic [7:0]  rd;
        logic [11:0] rgb;
        logic [3:0]  old_b;
        logic [7:0]  old_rd;

        for (int e = 0; e < 256; e++)
            for (int c = 0; c < 3; c++) exp_c[c][e] = 4'h0;
        m_idx = 8'd0; m_ph = 0;

        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1: reset state
        check("R1 pix", int'({pix_red, pix_grn, pix_blu}), 0);
        check("R1 rdata", int'(hst_rdata), 0);
        look(8'd200, 1'b0, rgb);
        check("R1 entry zero", int'(rgb), 0);
        hr(1'b0, rd);
        check("R1 index zero", int'(rd), 0);
        hr(1'b1, rd);
        check("R1 red zero", int'(rd), 0);
        hw(1'b0, 8'd0);

        // R2: index register readback
        hw(1'b0, 8'h3C);
        hr(1'b0, rd);
        check("R2 index readback", int'(rd), 8'h3C);

        // R3/R4: stream all entries after one index write
        hw(1'b0, 8'd0);
        for (int e = 0; e < 256; e++)
            for (int c = 0; c < 3; c++) hw(1'b1, pattern(e, c));
        hr(1'b0, rd);
        check("R4 wrap to 0", int'(rd), 0);

        // R6: lookup sweep
        for (int e = 0; e < 256; e++) begin
            look(8'(e), 1'b0, rgb);
            check("R6 lookup", int'(rgb), exp_rgb(e));
        end

        // R7: narrow mode sweep
        for (int e = 0; e < 256; e++) begin
            look(8'(e), 1'b1, rgb);
            check("R7 narrow", int'(rgb), exp_rgb(e % 16));
        end
        pix_narrow = 1'b0;

        // R5: host readback sweep
        hw(1'b0, 8'd0);
        for (int e = 0; e < 256; e++)
            for (int c = 0; c < 3; c++) begin
                hr(1'b1, rd);
                check("R5 readback", int'(rd), int'({exp_c[c][e], 4'h0}));
            end
        hr(1'b0, rd);
        check("R4 read wrap", int'(rd), 0);

        // R3: low nibble discarded
        hw(1'b0, 8'd77);
        hw(1'b1, 8'h5F);
        hw(1'b0, 8'd77);
        hr(1'b1, rd);
        check("R3 low nibble", int'(rd), 8'h50);

        // R2: index write mid-sequence returns phase to red
        hw(1'b0, 8'd9);
        hw(1'b1, 8'h10);
        hw(1'b0, 8'd9);
        hw(1'b1, 8'h20);
        look(8'd9, 1'b0, rgb);
        check("R2 phase reset red", int'(rgb[11:8]), 2);
        check("R2 green untouched", int'(rgb[7:4]), int'(pattern(9, 1) >> 4));

        // R4: explicit wrap 255 -> 0
        hw(1'b0, 8'd255);
        hw(1'b1, 8'h11); hw(1'b1, 8'h22); hw(1'b1, 8'h33);
        hw(1'b1, 8'hE0);
        look(8'd0, 1'b0, rgb);
        check("R4 wrap write red", int'(rgb[11:8]), 14);
        look(8'd255, 1'b0, rgb);
        check("R4 last entry", int'(rgb), 12'h123);

        // R8: lookup racing a write to the same entry
        hw(1'b0, 8'h20);
        hw(1'b1, 8'hA0);
        hw(1'b1, 8'hB0);
        old_b = exp_c[2][8'h20];
        pix_index = 8'h20; hst_sel = 1'b1; hst_wdata = 8'hC0; hst_wr = 1'b1;
        @(negedge clk);
        hst_wr = 1'b0;
        exp_c[2][8'h20] = 4'hC; model_step();
        check("R8 old value", int'(pix_blu), int'(old_b));
        @(negedge clk);
        check("R8 new value", int'(pix_blu), 12);

        // R9: simultaneous strobes
        hw(1'b0, 8'd5);
        old_rd = hst_rdata;
        hst_sel = 1'b1; hst_wdata = 8'h70; hst_wr = 1'b1; hst_rd = 1'b1;
        @(negedge clk);
        hst_wr = 1'b0; hst_rd = 1'b0;
        exp_c[0][5] = 4'h7; model_step();
        check("R9 rdata held", int'(hst_rdata), int'(old_rd));
        hw(1'b1, 8'h90);
        look(8'd5, 1'b0, rgb);
        check("R9 write taken", int'(rgb[11:8]), 7);
        check("R9 single advance", int'(rgb[7:4]), 9);

        done = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule